// File: doc/BRIEF.md
# Front Panel Operation Sequencer

This block turns a single front panel switch action on a small 8-bit computer into a short automatic pulse sequence on the auxiliary clock. There are six operations. Load Address copies the address switches into the program counter. Examine reads the byte that the PC points at into the A register. Deposit writes the data switches into that byte. Examine Next and Deposit Next do the same and then step the PC by one. Restart frees a processor that a program has halted, so no power cycle is needed.

The sequencer acts only while the processor is halted. It takes one request at a time and latches the PC and the switch words when it accepts a request. It then drives the memory address, the write strobe, the A-register load, the PC load and step controls, and the halt release for as many cycles as the operation needs. A program halt leaves the PC at the halted instruction plus one. The sequencer never changes the PC except through Load Address or a Next variant.

Top module: `panel_seq`

## Requirements
- R1: After reset, `busy`, `pc_load`, `pc_inc`, `mem_we`, `a_load` and `halt_release` are all 0.
- R2: A request is accepted only on a clock edge where `cpu_halted` is 1 and `busy` is 0. A request made while the processor runs has no effect: no busy, no strobe, and the PC, memory and A register stay unchanged.
- R3: When several requests are high together, exactly one is taken, in this priority from highest to lowest: restart, load address, deposit next, deposit, examine next, examine.
- R4: Load Address asserts `pc_load` for one cycle, with `pc_next` equal to the address switch value latched at acceptance. `busy` is high for 1 cycle.
- R5: Examine spends one address setup cycle with `mem_addr` equal to the latched PC. In the next cycle it asserts `a_load` for one cycle, with `a_data` equal to `mem_rdata`. `busy` is high for 2 cycles and the PC is unchanged.
- R6: Examine Next does an Examine and then asserts `pc_inc` for one cycle, with `pc_next` equal to the latched PC plus 1. `busy` is high for 3 cycles.
- R7: Deposit spends one address setup cycle. It then asserts `mem_we` for exactly one cycle, with `mem_wdata` equal to the data switches latched at acceptance and `mem_addr` equal to the latched PC. `busy` is high for 2 cycles.
- R8: Deposit Next does a Deposit and then asserts `pc_inc` for one cycle, with `pc_next` equal to the latched PC plus 1. `busy` is high for 3 cycles.
- R9: A PC step from 16'hFFFF gives 16'h0000.
- R10: Restart asserts `halt_release` for exactly one cycle, and `busy` is high for 1 cycle.
- R11: Requests that arrive while `busy` is high are dropped. No further operation starts once the current one ends.
- R12: In any cycle at most one of `pc_load`, `pc_inc`, `mem_we`, `a_load` and `halt_release` is high. `mem_addr` holds steady from the setup cycle through the access cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Auxiliary clock |
| rst_n | input | 1 | Active-low reset |
| cpu_halted | input | 1 | Processor is halted |
| pc_value | input | 16 | Current program counter |
| addr_sw | input | 16 | Address entry switches |
| data_sw | input | 8 | Data entry switches |
| req_examine | input | 1 | Examine request |
| req_examine_next | input | 1 | Examine Next request |
| req_deposit | input | 1 | Deposit request |
| req_deposit_next | input | 1 | Deposit Next request |
| req_load_addr | input | 1 | Load Address request |
| req_restart | input | 1 | Restart request |
| mem_rdata | input | 8 | Memory read data |
| busy | output | 1 | Sequence in progress |
| pc_load | output | 1 | Load PC from `pc_next` |
| pc_inc | output | 1 | Step PC to `pc_next` |
| pc_next | output | 16 | New PC value |
| mem_addr | output | 16 | Memory address |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| a_load | output | 1 | Load the A register |
| a_data | output | 8 | A register data |
| halt_release | output | 1 | Release the program halt |

## Verification
The bench runs examine-next and deposit-next at address 16'hFFFF. A design that carried into a seventeenth bit, or that stuck at the top, would leave the PC anywhere but zero. It raises several requests at once, and it raises fresh requests in the middle of a sequence. A design with the wrong priority would show the wrong busy length or the wrong side effect. A design that let a request in while busy would start a second sequence. Requests made while the processor runs must leave everything untouched. The bench also counts write pulses and busy cycles, so it would notice a strobe that lasts two cycles or a setup cycle that was skipped.

// File: rtl/panel_seq.sv
module panel_seq #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_halted,
  input  logic [AW-1:0] pc_value,
  input  logic [AW-1:0] addr_sw,
  input  logic [DW-1:0] data_sw,
  input  logic          req_examine,
  input  logic          req_examine_next,
  input  logic          req_deposit,
  input  logic          req_deposit_next,
  input  logic          req_load_addr,
  input  logic          req_restart,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          pc_load,
  output logic          pc_inc,
  output logic [AW-1:0] pc_next,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  output logic          a_load,
  output logic [DW-1:0] a_data,
  output logic          halt_release
);

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_ACCESS, S_STEP, S_LOAD, S_RELEASE
  } state_t;

  state_t        state;
  logic          is_wr, do_step;
  logic [AW-1:0] pc_lat, sw_lat;
  logic [DW-1:0] data_lat;
  logic          accept;

  assign accept = (state == S_IDLE) && cpu_halted &&
                  (req_examine | req_examine_next | req_deposit |
                   req_deposit_next | req_load_addr | req_restart);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      is_wr    <= 1'b0;
      do_step  <= 1'b0;
      pc_lat   <= '0;
      sw_lat   <= '0;
      data_lat <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          pc_lat   <= pc_value;
          sw_lat   <= addr_sw;
          data_lat <= data_sw;
          if (req_restart)           state <= S_RELEASE;
          else if (req_load_addr)    state <= S_LOAD;
          else begin
            state <= S_SETUP;
            if (req_deposit_next)      begin is_wr <= 1'b1; do_step <= 1'b1; end
            else if (req_deposit)      begin is_wr <= 1'b1; do_step <= 1'b0; end
            else if (req_examine_next) begin is_wr <= 1'b0; do_step <= 1'b1; end
            else                       begin is_wr <= 1'b0; do_step <= 1'b0; end
          end
        end
        S_SETUP:  state <= S_ACCESS;
        S_ACCESS: state <= do_step ? S_STEP : S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end

  assign busy         = (state != S_IDLE);
  assign pc_load      = (state == S_LOAD);
  assign pc_inc       = (state == S_STEP);
  assign pc_next      = pc_load ? sw_lat : pc_lat + 1'b1;
  assign mem_addr     = pc_lat;
  assign mem_we       = (state == S_ACCESS) && is_wr;
  assign mem_wdata    = data_lat;
  assign a_load       = (state == S_ACCESS) && !is_wr;
  assign a_data       = mem_rdata;
  assign halt_release = (state == S_RELEASE);

  // R7
  we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  // R12
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pc_load, pc_inc, mem_we, a_load, halt_release}));

  // R12
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || a_load) |-> $stable(mem_addr));

  // R2
  run_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cpu_halted) |=> !busy);

  // R6
  step_after_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pc_inc) |-> $past(mem_we || a_load));

  // R10
  release_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_release |=> !halt_release);

endmodule

// File: tb/test_panel_seq.sv
module test_panel_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_halted = 1'b0;
  logic [15:0] pc_value;
  logic [15:0] addr_sw = '0;
  logic [7:0]  data_sw = '0;
  logic [5:0]  reqs = '0;
  logic [7:0]  mem_rdata;
  logic        busy, pc_load, pc_inc, mem_we, a_load, halt_release;
  logic [15:0] pc_next, mem_addr;
  logic [7:0]  mem_wdata, a_data;

  always #2 clk = ~clk;

  panel_seq i_panel_seq (
    .clk(clk), .rst_n(rst_n), .cpu_halted(cpu_halted), .pc_value(pc_value),
    .addr_sw(addr_sw), .data_sw(data_sw),
    .req_examine(reqs[0]), .req_examine_next(reqs[1]), .req_deposit(reqs[2]),
    .req_deposit_next(reqs[3]), .req_load_addr(reqs[4]), .req_restart(reqs[5]),
    .mem_rdata(mem_rdata), .busy(busy), .pc_load(pc_load), .pc_inc(pc_inc),
    .pc_next(pc_next), .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .a_load(a_load), .a_data(a_data), .halt_release(halt_release)
  );

  logic [7:0]  mem [0:255];
  logic [15:0] pc = '0;
  logic [7:0]  a_reg = '0;
  int          we_cnt = 0, rel_cnt = 0;
  int          checks = 0, fails = 0;
  bit          done = 0;

  assign pc_value  = pc;
  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) if (rst_n) begin
    if (mem_we) begin mem[mem_addr[7:0]] <= mem_wdata; we_cnt <= we_cnt + 1; end
    if (a_load) a_reg <= a_data;
    if (pc_load || pc_inc) pc <= pc_next;
    if (halt_release) rel_cnt <= rel_cnt + 1;
  end

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int pick(logic [5:0] m, bit halted);
    if (!halted) return -1;
    for (int i = 5; i >= 0; i--) if (m[i]) return i;
    return -1;
  endfunction

  function automatic int op_len(int sel);
    case (sel)
      5, 4: return 1;
      3, 1: return 3;
      2, 0: return 2;
      default: return 0;
    endcase
  endfunction

  task automatic do_op(logic [5:0] m, logic [15:0] a, logic [7:0] d, bit halted,
                       logic [5:0] inj);
    int sel, n, we0, rel0;
    logic [15:0] pc0, pc_exp;
    logic [7:0] a_exp, m_exp;
    string tag;
    sel = pick(m, halted);
    @(negedge clk);
    cpu_halted = halted; addr_sw = a; data_sw = d; reqs = m;
    pc0 = pc; we0 = we_cnt; rel0 = rel_cnt;
    a_exp = a_reg; m_exp = mem[pc0[7:0]]; pc_exp = pc0;
    case (sel)
      0: begin a_exp = mem[pc0[7:0]]; tag = "R5"; end
      1: begin a_exp = mem[pc0[7:0]]; pc_exp = pc0 + 16'd1; tag = "R6"; end
      2: begin m_exp = d; tag = "R7"; end
      3: begin m_exp = d; pc_exp = pc0 + 16'd1; tag = "R8"; end
      4: begin pc_exp = a; tag = "R4"; end
      5: tag = "R10";
      default: tag = "R2";
    endcase
    @(negedge clk);
    reqs = (op_len(sel) >= 2) ? inj : 6'd0;
    n = 0;
    while (busy && n < 8) begin n++; @(negedge clk); reqs = '0; end
    chk({tag, "/R3 busy length"}, n, op_len(sel));
    chk({tag, " pc"}, pc, pc_exp);
    chk({tag, " a reg"}, a_reg, a_exp);
    chk({tag, " mem byte"}, mem[pc0[7:0]], m_exp);
    chk({tag, " write pulses"}, we_cnt - we0, (sel == 2 || sel == 3) ? 1 : 0);
    chk({tag, " release pulses"}, rel_cnt - rel0, (sel == 5) ? 1 : 0);
    @(negedge clk);
    chk("R11 idle after op", busy, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 strobes", {pc_load, pc_inc, mem_we, a_load, halt_release}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    do_op(6'b010000, 16'hFFFF, 8'h00, 1, 0);       // R4 load FFFF
    do_op(6'b000010, 16'h0000, 8'h00, 1, 0);       // R9 examine next wraps
    chk("R9 wrap", pc, 16'h0000);
    do_op(6'b010000, 16'hFFFF, 8'h00, 1, 0);
    do_op(6'b001000, 16'h0000, 8'h5A, 1, 0);       // R9 deposit next wraps
    chk("R9 wrap deposit", pc, 16'h0000);
    chk("R8 byte at FF", mem[8'hFF], 8'h5A);
    do_op(6'b111111, 16'h1234, 8'h11, 1, 0);       // R3 restart wins
    do_op(6'b011111, 16'h0040, 8'h22, 1, 0);       // R3 load wins
    do_op(6'b001111, 16'h0000, 8'h33, 1, 0);       // R3 deposit next wins
    do_op(6'b000111, 16'h0000, 8'h44, 1, 0);       // R3 deposit wins
    do_op(6'b000011, 16'h0000, 8'h00, 1, 0);       // R3 examine next wins
    do_op(6'b111111, 16'h9999, 8'hEE, 0, 0);       // R2 running: ignored
    do_op(6'b000100, 16'h0000, 8'h77, 1, 6'b010000); // R11 drop while busy
    do_op(6'b001000, 16'h0000, 8'h78, 1, 6'b100000); // R11
    do_op(6'b000001, 16'h0000, 8'h00, 1, 6'b000100); // R11
    for (int i = 0; i < 300; i++) begin
      logic [5:0] m;
      m = 6'($urandom);
      if (($urandom % 3) != 0) m = 6'd1 << ($urandom % 6);
      do_op(m, 16'($urandom), 8'($urandom), ($urandom % 5) != 0,
            (($urandom % 4) == 0) ? 6'($urandom) : 6'd0);
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule